// File: doc/BRIEF.md
# Status Packet Generator

This block reports a wide status vector to an upstream collector as a short byte-serial packet. A one-byte control write chooses how packets are produced: never, once, whenever the status differs from what was last reported, or continuously. The same write supplies a 6-bit sequence number. Each packet carries that number, so the collector can tell which control write a response belongs to.

When a packet is due, the block raises `pkt_req` and holds the status address byte on `pkt_byte`. The collector answers with a one-cycle `pkt_start` once it has taken that byte. On that edge the block captures the status vector. It then drives the remaining bytes on consecutive clocks. The first of these holds the sequence number in bits 7:2 and status bits 1:0 in bits 1:0. The following bytes hold status bits 9:2, 17:10 and 25:18. Between packets the bus reads zero. Arbitration between several generators is left to the collector.

Top module: `stat_pkt_gen`

## Requirements
- R1: After synchronous reset `pkt_req` is 0, `pkt_byte` is 0 and the mode is off, so status changes raise no request.
- R2: A control write (`ctl_we` high) takes the mode from `ctl_data[7:6]` (0 off, 1 single packet, 2 on change, 3 repeat) and the sequence number from `ctl_data[5:0]`.
- R3: After a write selecting mode 1 or 3, `pkt_req` is high on the second clock edge. While `pkt_req` is high, `pkt_byte` equals the address parameter (0x21 by default).
- R4: `pkt_req` is low on the cycle after an edge where `pkt_start` and `pkt_req` are both high. A `pkt_start` while `pkt_req` is low has no effect, and the bus stays zero.
- R5: After the start edge, `pkt_byte` carries {seq, status[1:0]}, then status[9:2], status[17:10] and status[25:18] on consecutive cycles. All of these come from the status vector sampled at the start edge, so later status changes do not alter them.
- R6: After the last byte the bus returns to zero, unless a new request begins on that same cycle.
- R7: In mode 1 exactly one packet is requested for each control write.
- R8: In mode 3 a new request, with the address byte on the bus, follows directly after the last byte of each packet.
- R9: In mode 2 a request is raised when the status differs from the vector captured in the last packet (zero after reset), and not while they are equal. A change that occurs during a packet raises the request right after that packet ends.
- R10: A write selecting mode 0 withdraws a pending request on the next edge. A packet already under way still completes with its captured bytes, and no new request follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_data | input | 8 | Control byte: mode in [7:6], sequence in [5:0] |
| status_in | input | PAYLOAD_W | Status vector to report |
| pkt_req | output | 1 | Request to send a packet |
| pkt_start | input | 1 | Collector has taken the address byte |
| pkt_byte | output | 8 | Packet byte bus, zero when idle |

## Verification
The bench changes the status right after the start edge. A design that sampled the status late would send the new value instead of the captured one. In repeat mode and in change mode, the bench checks that the next request starts exactly on the cycle after the last byte. A design that re-armed too early would cut into the packet, and one that re-armed too late would leave a zero gap. A stray `pkt_start` with no request pending, and a mode-off write landing mid-packet, are both applied. These catch a generator that starts an unrequested packet, truncates one already under way, or keeps re-requesting after being switched off.

// File: rtl/sp_pkg.sv
package sp_pkg;

  localparam int SP_MODE_W = 2;
  localparam int SP_SEQ_W  = 8 - SP_MODE_W;

  typedef enum logic [SP_MODE_W-1:0] {
    SP_OFF      = 2'd0,
    SP_ONCE     = 2'd1,
    SP_ONCHANGE = 2'd2,
    SP_REPEAT   = 2'd3
  } sp_mode_e;

  // bytes following the address byte: one for {seq, low two bits}, then
  // the remaining payload bits eight at a time
  function automatic int sp_tail_bytes(input int payload_w);
    return 1 + (payload_w - 2 + 7) / 8;
  endfunction

endpackage

// File: rtl/sp_ctrl.sv
module sp_ctrl
  import sp_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [7:0]          wr_byte,
  input  logic                start_acc,
  output sp_mode_e            mode_q,
  output logic [SP_SEQ_W-1:0] seq_q,
  output logic                armed_q
);

  sp_mode_e wr_mode;
  assign wr_mode = sp_mode_e'(wr_byte[7:SP_SEQ_W]);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= SP_OFF;
      seq_q   <= '0;
      armed_q <= 1'b0;
    end else if (wr_en) begin
      mode_q  <= wr_mode;
      seq_q   <= wr_byte[SP_SEQ_W-1:0];
      armed_q <= (wr_mode == SP_ONCE) || (wr_mode == SP_REPEAT);
    end else if (start_acc) begin
      armed_q <= (mode_q == SP_REPEAT);
    end
  end

  // R7: a single-packet arm is consumed by the accepted start
  a_r7_once_disarms: assert property (@(posedge clk) disable iff (rst)
    (start_acc && !wr_en && mode_q == SP_ONCE) |=> !armed_q);

endmodule

// File: rtl/sp_handshake.sv
module sp_handshake
  import sp_pkg::*;
#(
  parameter int PAYLOAD_W = 26
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  sp_mode_e             wr_mode,
  input  sp_mode_e             mode_q,
  input  logic                 armed_q,
  input  logic                 ser_free,
  input  logic [PAYLOAD_W-1:0] status_in,
  input  logic                 pkt_start,
  output logic                 start_acc,
  output logic                 req_d,
  output logic                 req_q
);

  logic [PAYLOAD_W-1:0] last_sent_q;
  logic                 differs;

  assign start_acc = req_q && pkt_start;
  assign differs   = (status_in != last_sent_q);

  always_comb begin
    if (start_acc)
      req_d = 1'b0;
    else if (wr_en && wr_mode == SP_OFF)
      req_d = 1'b0;
    else if (req_q)
      req_d = 1'b1;
    else if (ser_free && (armed_q || (mode_q == SP_ONCHANGE && differs)))
      req_d = 1'b1;
    else
      req_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q       <= 1'b0;
      last_sent_q <= '0;
    end else begin
      req_q <= req_d;
      if (start_acc)
        last_sent_q <= status_in;
    end
  end

  // R4: the request is withdrawn once the start is seen
  a_r4_req_drops: assert property (@(posedge clk) disable iff (rst)
    (req_q && pkt_start) |=> !req_q);

  // R4: no request can appear out of an idle bus without a reason
  a_r4_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (!req_q && pkt_start && !armed_q && mode_q != SP_ONCHANGE) |=> !req_q);

endmodule

// File: rtl/sp_serializer.sv
module sp_serializer
  import sp_pkg::*;
#(
  parameter int         PAYLOAD_W = 26,
  parameter logic [7:0] ADDR_BYTE = 8'h21
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_acc,
  input  logic                 req_d,
  input  logic [SP_SEQ_W-1:0]  seq_q,
  input  logic [PAYLOAD_W-1:0] status_in,
  output logic                 busy_q,
  output logic                 ser_free,
  output logic [7:0]           pkt_byte
);

  localparam int TAIL_B = sp_tail_bytes(PAYLOAD_W);
  localparam int TAIL_W = TAIL_B * 8;
  localparam int SH_W   = TAIL_W - 8;
  localparam int LEFT_W = $clog2(TAIL_B + 1);
  localparam logic [LEFT_W-1:0] LEFT_INIT = LEFT_W'(TAIL_B - 1);

  logic [TAIL_W-1:0] tail_w;
  logic [SH_W-1:0]   sh_q;
  logic [LEFT_W-1:0] left_q;

  always_comb begin
    tail_w = '0;
    tail_w[1:0]                = status_in[1:0];
    tail_w[7:2]                = seq_q;
    tail_w[8 +: PAYLOAD_W - 2] = status_in[PAYLOAD_W-1:2];
  end

  assign ser_free = !busy_q || (left_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      left_q   <= '0;
      sh_q     <= '0;
      pkt_byte <= '0;
    end else if (start_acc) begin
      busy_q   <= 1'b1;
      left_q   <= LEFT_INIT;
      sh_q     <= tail_w[TAIL_W-1:8];
      pkt_byte <= tail_w[7:0];
    end else if (busy_q && left_q != '0) begin
      left_q   <= left_q - 1'b1;
      sh_q     <= sh_q >> 8;
      pkt_byte <= sh_q[7:0];
    end else begin
      busy_q   <= 1'b0;
      pkt_byte <= req_d ? ADDR_BYTE : 8'h00;
    end
  end

  // R5: the byte count of a packet never exceeds the tail length
  a_r5_left_bound: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (left_q <= LEFT_INIT));

  // R5: a started packet keeps streaming until its count runs out
  a_r5_stream_on: assert property (@(posedge clk) disable iff (rst)
    (busy_q && left_q != '0) |=> busy_q);

endmodule

// File: rtl/stat_pkt_gen.sv
module stat_pkt_gen
  import sp_pkg::*;
#(
  parameter int         PAYLOAD_W = 26,
  parameter logic [7:0] ADDR_BYTE = 8'h21
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ctl_we,
  input  logic [7:0]           ctl_data,
  input  logic [PAYLOAD_W-1:0] status_in,
  output logic                 pkt_req,
  input  logic                 pkt_start,
  output logic [7:0]           pkt_byte
);

  sp_mode_e            mode_q;
  sp_mode_e            wr_mode;
  logic [SP_SEQ_W-1:0] seq_q;
  logic                armed_q;
  logic                start_acc;
  logic                req_d;
  logic                ser_free;
  logic                busy_q;

  assign wr_mode = sp_mode_e'(ctl_data[7:SP_SEQ_W]);

  sp_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (ctl_we),
    .wr_byte   (ctl_data),
    .start_acc (start_acc),
    .mode_q    (mode_q),
    .seq_q     (seq_q),
    .armed_q   (armed_q)
  );

  sp_handshake #(
    .PAYLOAD_W (PAYLOAD_W)
  ) u_hs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (ctl_we),
    .wr_mode   (wr_mode),
    .mode_q    (mode_q),
    .armed_q   (armed_q),
    .ser_free  (ser_free),
    .status_in (status_in),
    .pkt_start (pkt_start),
    .start_acc (start_acc),
    .req_d     (req_d),
    .req_q     (pkt_req)
  );

  sp_serializer #(
    .PAYLOAD_W (PAYLOAD_W),
    .ADDR_BYTE (ADDR_BYTE)
  ) u_ser (
    .clk       (clk),
    .rst       (rst),
    .start_acc (start_acc),
    .req_d     (req_d),
    .seq_q     (seq_q),
    .status_in (status_in),
    .busy_q    (busy_q),
    .ser_free  (ser_free),
    .pkt_byte  (pkt_byte)
  );

  // R3: the address byte is on the bus for as long as the request stands
  a_r3_addr_on_req: assert property (@(posedge clk) disable iff (rst)
    pkt_req |-> (pkt_byte == ADDR_BYTE));

  // R6: the bus is quiet when neither requesting nor streaming
  a_r6_idle_zero: assert property (@(posedge clk) disable iff (rst)
    (!pkt_req && !busy_q) |-> (pkt_byte == 8'h00));

  // R5: requesting and streaming never overlap
  a_r5_req_busy_excl: assert property (@(posedge clk) disable iff (rst)
    !(pkt_req && busy_q));

  // R10: switching off withdraws the request at once
  a_r10_off_drops: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && ctl_data[7:6] == 2'd0) |=> !pkt_req);

endmodule

// File: tb/stat_pkt_gen_tb.sv
module stat_pkt_gen_tb;

  localparam int  PW    = 26;
  localparam time CLK_P = 5ns;

  logic          clk = 1'b0;
  logic          rst;
  logic          ctl_we;
  logic [7:0]    ctl_data;
  logic [PW-1:0] status_in;
  logic          pkt_req;
  logic          pkt_start;
  logic [7:0]    pkt_byte;

  int n_checks = 0;
  int n_err    = 0;

  always #(CLK_P/2) clk = ~clk;

  stat_pkt_gen #(.PAYLOAD_W(PW), .ADDR_BYTE(8'h21)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .ctl_we    (ctl_we),
    .ctl_data  (ctl_data),
    .status_in (status_in),
    .pkt_req   (pkt_req),
    .pkt_start (pkt_start),
    .pkt_byte  (pkt_byte)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int idx, input logic [5:0] sq,
                                          input logic [PW-1:0] st);
    case (idx)
      1:       return {sq, st[1:0]};
      2:       return st[9:2];
      3:       return st[17:10];
      default: return st[25:18];
    endcase
  endfunction

  task automatic wr_ctl(input logic [1:0] md, input logic [5:0] sq);
    ctl_we   = 1'b1;
    ctl_data = {md, sq};
    @(negedge clk);
    ctl_we   = 1'b0;
    ctl_data = 8'h00;
  endtask

  // called at a falling edge with the request standing
  task automatic take_packet(input logic [5:0] sq, input logic [PW-1:0] st_cap,
                             input logic [PW-1:0] st_after, input logic [PW-1:0] st_mid,
                             input logic off_mid);
    status_in = st_cap;
    pkt_start = 1'b1;
    @(negedge clk);
    pkt_start = 1'b0;
    status_in = st_after;
    chk("R4 req drops after start", {31'd0, pkt_req}, 32'd0);
    chk("R2 R5 byte1 seq and low bits", {24'd0, pkt_byte}, {24'd0, exp_byte(1, sq, st_cap)});
    for (int i = 2; i <= 4; i++) begin
      @(negedge clk);
      ctl_we = 1'b0;
      chk("R5 payload byte", {24'd0, pkt_byte}, {24'd0, exp_byte(i, sq, st_cap)});
      if (i == 2) begin
        status_in = st_mid;
        if (off_mid) begin
          ctl_we   = 1'b1;
          ctl_data = 8'h00;
        end
      end
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; ctl_we = 1'b0; ctl_data = 8'h00; status_in = '0; pkt_start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset req", {31'd0, pkt_req}, 32'd0);
    chk("R1 reset bus", {24'd0, pkt_byte}, 32'd0);
    status_in = 26'h1234567;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      status_in = status_in + 26'h0101;
      chk("R1 mode off no req", {31'd0, pkt_req}, 32'd0);
    end
  endtask

  task automatic t_once();
    wr_ctl(2'd1, 6'h05);
    @(negedge clk);
    chk("R3 req after single write", {31'd0, pkt_req}, 32'd1);
    chk("R3 address byte", {24'd0, pkt_byte}, 32'h21);
    take_packet(6'h05, 26'h2F0A5C3, 26'h0ABCDEF, 26'h0ABCDEF, 1'b0);
    @(negedge clk);
    chk("R6 bus zero after packet", {24'd0, pkt_byte}, 32'd0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R7 single mode no repeat", {31'd0, pkt_req}, 32'd0);
    end
  endtask

  task automatic t_stray();
    pkt_start = 1'b1;
    @(negedge clk);
    pkt_start = 1'b0;
    chk("R4 stray start req", {31'd0, pkt_req}, 32'd0);
    chk("R4 stray start bus", {24'd0, pkt_byte}, 32'd0);
    @(negedge clk);
    chk("R4 stray start bus later", {24'd0, pkt_byte}, 32'd0);
  endtask

  task automatic t_repeat();
    wr_ctl(2'd3, 6'h3F);
    @(negedge clk);
    chk("R3 req after repeat write", {31'd0, pkt_req}, 32'd1);
    take_packet(6'h3F, 26'h155AA33, 26'h3FFFFFF, 26'h3FFFFFF, 1'b0);
    @(negedge clk);
    chk("R8 back-to-back req", {31'd0, pkt_req}, 32'd1);
    chk("R8 back-to-back address", {24'd0, pkt_byte}, 32'h21);
    take_packet(6'h3F, 26'h0C3_96E1, 26'h0000001, 26'h0000002, 1'b1);
    @(negedge clk);
    ctl_we = 1'b0;
    chk("R10 no req after off mid-packet", {31'd0, pkt_req}, 32'd0);
    chk("R10 bus zero after off", {24'd0, pkt_byte}, 32'd0);
    @(negedge clk);
    chk("R10 still idle", {31'd0, pkt_req}, 32'd0);
  endtask

  task automatic t_change();
    status_in = 26'h0C3_96E1;
    wr_ctl(2'd2, 6'h09);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R9 no req while equal", {31'd0, pkt_req}, 32'd0);
    end
    status_in = 26'h2468ACE;
    @(negedge clk);
    chk("R9 req on change", {31'd0, pkt_req}, 32'd1);
    take_packet(6'h09, 26'h2468ACE, 26'h2468ACE, 26'h1357BDF, 1'b0);
    @(negedge clk);
    chk("R9 req after change during packet", {31'd0, pkt_req}, 32'd1);
    chk("R9 address after change", {24'd0, pkt_byte}, 32'h21);
    take_packet(6'h09, 26'h1357BDF, 26'h1357BDF, 26'h1357BDF, 1'b0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R9 quiet once reported", {31'd0, pkt_req}, 32'd0);
    end
  endtask

  task automatic t_withdraw();
    status_in = 26'h0000F0F;
    @(negedge clk);
    chk("R9 req before withdraw", {31'd0, pkt_req}, 32'd1);
    wr_ctl(2'd0, 6'h00);
    chk("R10 withdraw req", {31'd0, pkt_req}, 32'd0);
    chk("R10 withdraw bus", {24'd0, pkt_byte}, 32'd0);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_once();
    t_stray();
    t_repeat();
    t_change();
    t_withdraw();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule